// File: doc/BRIEF.md
# Quad-Collision Lane Group Sequencer

This block turns a per-quad collision mask into a sequence of lane masks, so that a wave can run an ordered code region in successive subsets. Every quad is four adjacent lanes. A set bit at quad q says that quad begins a new overlap layer: lanes 4*q and above may enter the ordered region only once every lane below 4*q has left it. The sequencer therefore cuts the wave at each set bit. Each cut yields one group made of a contiguous run of quads.

A pulse on `start_i` captures the mask and the wave width, which is 32 or 64 lanes. The sequencer then offers the first group on a valid/ready output. Each accepted group moves it to the next one. The final group carries `grp_last_o`. After that group is accepted, the output goes idle until the next start.

Back-pressure rules:
- While `grp_valid_o` is high and `grp_ready_i` is low, the offered group stays unchanged.
- A group is consumed on a clock edge where both signals are high.
- `start_i` takes priority over a handshake in the same cycle.
- A start that arrives mid-sequence abandons the old sequence.

Top module: `qlane_group_seq`

## Requirements
- R1: After reset `grp_valid_o` is 0 and `grp_lanes_o` is all zeros. Whenever `grp_valid_o` is 0, `grp_lanes_o` is zero.
- R2: After a clock edge that samples `start_i` high, `grp_valid_o` is 1 and the offered group includes lane 0.
- R3: Each group covers quads from its start quad up to, but not including, the next set mask bit above the start quad. Quad q is driven as lanes 4*q to 4*q+3 of `grp_lanes_o`.
- R4: `grp_last_o` is 1 exactly when no set mask bit lies above the current start quad. The final group reaches the top lane of the selected wave width (lane 31 or lane 63).
- R5: When `wide_i` is 0 at start (32 lanes), mask bits 15:8 are ignored and lanes 63:32 are never driven. When `wide_i` is 1 (64 lanes), all 16 mask bits are used.
- R6: A mask with no set bits in range gives a single group covering the whole wave, with `grp_last_o` set.
- R7: A set bit at quad 0 never produces an empty group.
- R8: While `grp_valid_o` is 1 and `grp_ready_i` is 0 (with no start), the lane mask and last flag stay unchanged.
- R9: Accepting the group flagged last drops `grp_valid_o` on the next cycle.
- R10: A start during a sequence discards it and begins again at lane 0 with the new mask and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture mask and width, restart at the first group |
| coll_mask_i | input | 16 | Per-quad new-layer bits |
| wide_i | input | 1 | 1 = 64-lane wave, 0 = 32-lane wave |
| grp_ready_i | input | 1 | Consumer accepts the offered group |
| grp_valid_o | output | 1 | A group is offered |
| grp_lanes_o | output | 64 | Active lane mask of the offered group |
| grp_last_o | output | 1 | Offered group is the final one |

## Verification
The bench aims at the following corner cases:

- **Bit at quad 0.** A sequencer that honoured it would offer an all-zero group.
- **Upper mask bits in 32-lane mode.** If they leaked through, the bench would see extra splits or lanes above 31.
- **Boundary quad placement.** A wrong find-first search would merge or misplace groups. The bench checks this with the five-group pattern {2,7,8,9} and with a mask that has every bit set.
- **Stalled handshake.** A design that advanced without ready would skip a group.
- **Mid-sequence restart.** A design that kept its old position would start the new mask partway up the wave.

// File: rtl/qlgs_pkg.sv
`timescale 1ns/1ps
package qlgs_pkg;
  localparam int unsigned QUAD_LANES = 4;

  typedef enum logic {
    WAVE_NARROW = 1'b0,
    WAVE_WIDE   = 1'b1
  } wave_mode_e;
endpackage

// File: rtl/qlgs_mask_trim.sv
`timescale 1ns/1ps
// Clears the quad-0 bit and every bit beyond the selected wave width.
module qlgs_mask_trim #(
  parameter int unsigned NQ        = 16,
  parameter int unsigned NARROW_NQ = 8
) (
  input  logic [NQ-1:0] mask_i,
  input  logic          wide_i,
  output logic [NQ-1:0] mask_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_keep
    if (q == 0) begin : g_first
      assign mask_o[q] = 1'b0;
    end else if (q < NARROW_NQ) begin : g_low
      assign mask_o[q] = mask_i[q];
    end else begin : g_high
      assign mask_o[q] = mask_i[q] & wide_i;
    end
  end
endmodule

// File: rtl/qlgs_next_edge.sv
`timescale 1ns/1ps
// Lowest set bit strictly above from_i.
module qlgs_next_edge #(
  parameter int unsigned NQ = 16,
  parameter int unsigned QW = 5
) (
  input  logic [NQ-1:0] mask_i,
  input  logic [QW-1:0] from_i,
  output logic          hit_o,
  output logic [QW-1:0] pos_o
);
  always_comb begin
    hit_o = 1'b0;
    pos_o = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (mask_i[i] && (QW'(i) > from_i)) begin
        hit_o = 1'b1;
        pos_o = QW'(i);
      end
    end
  end
endmodule

// File: rtl/qlgs_lane_span.sv
`timescale 1ns/1ps
// Expands a half-open quad range [lo_i, hi_i) into a lane mask.
module qlgs_lane_span #(
  parameter int unsigned NQ  = 16,
  parameter int unsigned LPQ = 4,
  parameter int unsigned QW  = 5
) (
  input  logic [QW-1:0]     lo_i,
  input  logic [QW-1:0]     hi_i,
  input  logic              en_i,
  output logic [NQ*LPQ-1:0] lanes_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_quad
    assign lanes_o[q*LPQ +: LPQ] =
      {LPQ{en_i && (QW'(q) >= lo_i) && (QW'(q) < hi_i)}};
  end
endmodule

// File: rtl/qlane_group_seq.sv
`timescale 1ns/1ps
module qlane_group_seq
  import qlgs_pkg::*;
#(
  parameter int unsigned MAX_QUADS    = 16,
  parameter int unsigned NARROW_QUADS = 8,
  localparam int unsigned MAX_LANES   = MAX_QUADS * QUAD_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [MAX_QUADS-1:0] coll_mask_i,
  input  logic                 wide_i,
  input  logic                 grp_ready_i,
  output logic                 grp_valid_o,
  output logic [MAX_LANES-1:0] grp_lanes_o,
  output logic                 grp_last_o
);
  localparam int unsigned QW           = $clog2(MAX_QUADS + 1);
  localparam int unsigned NARROW_LANES = NARROW_QUADS * QUAD_LANES;

  logic                 valid_q;
  logic [QW-1:0]        cur_q;
  logic [MAX_QUADS-1:0] mask_q;
  wave_mode_e           mode_q;

  logic [MAX_QUADS-1:0] mask_trim;
  logic                 hit;
  logic [QW-1:0]        nxt;
  logic [QW-1:0]        end_q;
  logic [QW-1:0]        wave_quads;

  qlgs_mask_trim #(.NQ(MAX_QUADS), .NARROW_NQ(NARROW_QUADS)) u_trim (
    .mask_i (coll_mask_i),
    .wide_i (wide_i),
    .mask_o (mask_trim)
  );

  qlgs_next_edge #(.NQ(MAX_QUADS), .QW(QW)) u_edge (
    .mask_i (mask_q),
    .from_i (cur_q),
    .hit_o  (hit),
    .pos_o  (nxt)
  );

  assign wave_quads = (mode_q == WAVE_WIDE) ? QW'(MAX_QUADS) : QW'(NARROW_QUADS);
  assign end_q      = hit ? nxt : wave_quads;

  qlgs_lane_span #(.NQ(MAX_QUADS), .LPQ(QUAD_LANES), .QW(QW)) u_span (
    .lo_i    (cur_q),
    .hi_i    (end_q),
    .en_i    (valid_q),
    .lanes_o (grp_lanes_o)
  );

  assign grp_valid_o = valid_q;
  assign grp_last_o  = valid_q & ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cur_q   <= '0;
      mask_q  <= '0;
      mode_q  <= WAVE_NARROW;
    end else if (start_i) begin
      valid_q <= 1'b1;
      cur_q   <= '0;
      mask_q  <= mask_trim;
      mode_q  <= wave_mode_e'(wide_i);
    end else if (valid_q && grp_ready_i) begin
      if (!hit) begin
        valid_q <= 1'b0;
      end else begin
        cur_q <= nxt;
      end
    end
  end

  // R2: a start leads to an offered group that contains lane 0
  a_r2_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (grp_valid_o && grp_lanes_o[0]));

  // R7: no empty group is ever offered
  a_r7_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid_o |-> (grp_lanes_o != '0));

  // R5: a narrow wave never drives the upper lanes
  a_r5_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid_o && mode_q == WAVE_NARROW) |->
      (grp_lanes_o[MAX_LANES-1:NARROW_LANES] == '0));

  // R4: the final group reaches the top lane of the wave
  a_r4_last_top: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid_o && grp_last_o) |->
      ((mode_q == WAVE_WIDE) ? grp_lanes_o[MAX_LANES-1] : grp_lanes_o[NARROW_LANES-1]));

  // R8: a stalled group is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid_o && !grp_ready_i && !start_i) |=>
      (grp_valid_o && $stable(grp_lanes_o) && $stable(grp_last_o)));

  // R9: accepting the final group ends the sequence
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid_o && grp_ready_i && grp_last_o && !start_i) |=> !grp_valid_o);

  // R1: idle output carries no lanes
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid_o |-> (grp_lanes_o == '0 && !grp_last_o));
endmodule

// File: tb/qlane_group_seq_bench.sv
`timescale 1ns/1ps
module qlane_group_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] coll_mask_i = '0;
  logic        wide_i = 1'b0;
  logic        grp_ready_i = 1'b0;
  logic        grp_valid_o;
  logic [63:0] grp_lanes_o;
  logic        grp_last_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  qlane_group_seq u_qlane_group_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .coll_mask_i (coll_mask_i),
    .wide_i      (wide_i),
    .grp_ready_i (grp_ready_i),
    .grp_valid_o (grp_valid_o),
    .grp_lanes_o (grp_lanes_o),
    .grp_last_o  (grp_last_o)
  );

  function automatic logic [63:0] span(int lo, int hi);
    logic [63:0] m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: capture mask/width, next negedge has the first group.
  task automatic do_start(logic [15:0] m, logic w);
    coll_mask_i = m;
    wide_i      = w;
    start_i     = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
    coll_mask_i = 16'hFFFF;
    wide_i      = ~w;
  endtask

  // Checks the offered group, then accepts it.
  task automatic take(string req, logic [63:0] lanes, logic last);
    check(req, {grp_valid_o, grp_last_o, grp_lanes_o}, {1'b1, last, lanes});
    grp_ready_i = 1'b1;
    @(negedge clk);
    grp_ready_i = 1'b0;
  endtask

  task automatic expect_idle(string req);
    check(req, {grp_valid_o, grp_last_o, grp_lanes_o}, 66'd0);
  endtask

  task automatic t_reset();
    expect_idle("R1 reset");
  endtask

  task automatic t_example();
    do_start(16'h0384, 1'b1);
    take("R2 R3 group0", span(0, 7), 1'b0);
    take("R3 group1", span(8, 27), 1'b0);
    take("R3 group2", span(28, 31), 1'b0);
    take("R3 group3", span(32, 35), 1'b0);
    take("R4 final", span(36, 63), 1'b1);
    expect_idle("R9 after last");
  endtask

  task automatic t_zero();
    do_start(16'h0000, 1'b1);
    take("R6 wide single", span(0, 63), 1'b1);
    expect_idle("R9 zero wide");
    do_start(16'h0000, 1'b0);
    take("R6 R5 narrow single", span(0, 31), 1'b1);
    expect_idle("R9 zero narrow");
  endtask

  task automatic t_narrow_high();
    do_start(16'hFF10, 1'b0);
    take("R5 narrow g0", span(0, 15), 1'b0);
    take("R5 narrow g1", span(16, 31), 1'b1);
    expect_idle("R5 narrow end");
  endtask

  task automatic t_quad0();
    do_start(16'h0003, 1'b1);
    take("R7 quad0 g0", span(0, 3), 1'b0);
    take("R7 quad0 g1", span(4, 63), 1'b1);
  endtask

  task automatic t_all_bits();
    do_start(16'h00FF, 1'b0);
    for (int g = 0; g < 8; g++)
      take("R3 every quad", span(4 * g, 4 * g + 3), g == 7);
    expect_idle("R9 every quad end");
  endtask

  task automatic t_stall();
    do_start(16'h0100, 1'b1);
    for (int k = 0; k < 4; k++) begin
      check("R8 stall hold", {grp_valid_o, grp_last_o, grp_lanes_o}, {2'b10, span(0, 31)});
      @(negedge clk);
    end
    take("R8 after stall g0", span(0, 31), 1'b0);
    take("R8 after stall g1", span(32, 63), 1'b1);
  endtask

  task automatic t_restart();
    do_start(16'h0384, 1'b1);
    take("R10 pre g0", span(0, 7), 1'b0);
    grp_ready_i = 1'b1;
    do_start(16'h8000, 1'b1);
    grp_ready_i = 1'b0;
    take("R10 restart g0", span(0, 59), 1'b0);
    take("R10 restart g1", span(60, 63), 1'b1);
    expect_idle("R10 restart end");
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_zero();
    t_narrow_high();
    t_quad0();
    t_all_bits();
    t_stall();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule